// File: doc/BRIEF.md
# Binary64 Pack and Round Unit

This block turns an intermediate floating-point result into a 64-bit IEEE binary64 word. It takes a sign bit, a signed unbiased exponent and a 55-bit working mantissa. The value they stand for is the mantissa times two to the power of the exponent. A normalised mantissa has its top bit (bit 54) set. The two lowest bits are extra precision: bit 1 is the guard bit and bit 0 is a sticky bit that is set when any lower bits were non-zero.

The block rounds to nearest, with ties going to even. It flushes results that are too small to signed zero. All of this is done with masks and one addition, with no data-dependent branching. If the exponent is too large, the result is unspecified.

A producer asserts `inValid` with the three operands. The packed word appears in a register one clock later, marked by `outValid`, and stays there until the next accepted operand.

Top module: `fpack_round_unit`

## Requirements
- R1: Normal encoding. Applies when inMant bit 54 is set and inExp lies in -1076..969 with no rounding carry. Output bit 63 is inSign, bits 62..52 hold inExp+1077, and bits 51..0 hold inMant bits 53..2 plus the rounding increment.
- R2: Rounding. The packed word is incremented by one exactly when inMant bits 2..0 equal 3'b011, 3'b110 or 3'b111. The patterns 000, 001, 010, 100 and 101 leave it unchanged. This is round to nearest, ties to even.
- R3: A rounding increment that overflows the fraction carries into the exponent field. For example, an all-ones mantissa gives a fraction of zero and an exponent field of inExp+1078.
- R4: When inExp is below -1076, the output is a zero that carries inSign: bits 62..0 are zero, whatever the mantissa.
- R5: When inMant bit 54 is clear and inExp is at least -1076, the exponent contributes nothing. The output equals (inSign<<63) + (inMant>>2) + rounding increment. In particular, a zero mantissa gives a signed zero.
- R6: inExp = -1076 with a normalised mantissa is still encoded as a normal number, with exponent field 1.
- R7: outValid is high in the cycle after each cycle with inValid high, and low otherwise. Back-to-back operands each produce their own result.
- R8: outWord holds its value, and ignores the operand inputs, while inValid is low.
- R9: After reset, outValid is 0 and outWord is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands on the inputs are valid this cycle |
| inSign | input | 1 | Sign of the value, 1 = negative |
| inExp | input | 16 | Unbiased exponent, two's complement |
| inMant | input | 55 | Working mantissa; bit 54 is the leading one, bit 0 is sticky |
| outValid | output | 1 | outWord carries a new result this cycle |
| outWord | output | 64 | Packed binary64 word |

## Verification
Each result is due exactly one clock after the cycle in which its operands are presented with `inValid` high. The bench drives operands on a falling edge and samples `outValid` and `outWord` on the next falling edge, after one register stage. One falling edge later it checks that `outValid` has dropped and that `outWord` is unchanged, even though the operand inputs were scrambled in the meantime. A back-to-back pair checks that each result appears in its own cycle. The expected words come from a separate model of round-half-even arithmetic, not from a rounding table.

// File: rtl/fpack_pkg.sv
package fpack_pkg;

  // Default geometry of the binary64 encoding and of the working operands.
  localparam int unsigned DEF_WORD_W = 64;
  localparam int unsigned DEF_FRAC_W = 52;
  localparam int unsigned DEF_EXP_W  = 16;
  localparam int unsigned DEF_MANT_W = 55;

  // Added to the unbiased exponent before packing. The leading mantissa
  // bit lands on the exponent LSB and contributes the final +1.
  localparam int DEF_BIAS_OFF = 1076;

  // Bit n set means round up when the low three mantissa bits equal n.
  localparam logic [7:0] ROUND_UP_LUT = 8'b1100_1000;

  // Strobes from the control part to the datapath.
  typedef struct packed {
    logic load;
  } packStrobe_t;

endpackage

// File: rtl/fpack_round_lut.sv
module fpack_round_lut
  import fpack_pkg::*;
(
  input  logic [2:0] lowBits,
  output logic       roundUp
);

  always_comb begin
    roundUp = ROUND_UP_LUT[lowBits];
  end

endmodule

// File: rtl/fpack_ctrl.sv
module fpack_ctrl
  import fpack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output packStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.load = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R7
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R7

endmodule

// File: rtl/fpack_datapath.sv
module fpack_datapath
  import fpack_pkg::*;
#(
  parameter int unsigned WORD_W   = DEF_WORD_W,
  parameter int unsigned FRAC_W   = DEF_FRAC_W,
  parameter int unsigned EXP_W    = DEF_EXP_W,
  parameter int unsigned MANT_W   = DEF_MANT_W,
  parameter int          BIAS_OFF = DEF_BIAS_OFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  packStrobe_t       strobe,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [MANT_W-1:0] inMant,
  output logic [WORD_W-1:0] outWord
);

  // Width of the field above the fraction (exponent plus sign position).
  localparam int unsigned TOP_W   = WORD_W - FRAC_W;
  localparam int unsigned FIELD_W = TOP_W - 1;
  localparam int unsigned ADJ_W   = EXP_W + 1;
  // Largest exponent that still gives a finite normal result.
  localparam int          MAX_NORM_E = (1 << FIELD_W) - 2 - (BIAS_OFF + 1);

  logic [ADJ_W-1:0]  expAdj;
  logic              underflow;
  logic [MANT_W-1:0] mantClamp;
  logic              leadBit;
  logic [ADJ_W-1:0]  expKeep;
  logic [WORD_W-1:0] baseWord;
  logic [WORD_W-1:0] expAddend;
  logic              roundUp;
  logic [WORD_W-1:0] packedWord;
  logic [WORD_W-1:0] resultQ;

  // Sign-extended add of the bias offset; negative means underflow.
  always_comb begin
    expAdj    = {inExp[EXP_W-1], inExp} + ADJ_W'(BIAS_OFF);
    underflow = expAdj[ADJ_W-1];
  end

  // Underflow clears the mantissa; a missing leading one clears the exponent.
  always_comb begin
    mantClamp = underflow ? '0 : inMant;
    leadBit   = mantClamp[MANT_W-1];
    expKeep   = leadBit ? expAdj : '0;
  end

  // Drop the guard and sticky bits and keep the leading one. The leading
  // one overlaps the exponent LSB and adds one to the biased exponent.
  always_comb begin
    baseWord  = {inSign, {(WORD_W-1){1'b0}}} | WORD_W'(mantClamp >> 2);
    expAddend = {expKeep[TOP_W-1:0], {FRAC_W{1'b0}}};
  end

  fpack_round_lut u_roundLut (
    .lowBits (mantClamp[2:0]),
    .roundUp (roundUp)
  );

  // A single adder; a rounding carry may ripple into the exponent field.
  always_comb begin
    packedWord = baseWord + expAddend + WORD_W'(roundUp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobe.load) begin
      resultQ <= packedWord;
    end
  end

  assign outWord = resultQ;

  AST_UNDERFLOW_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && ($signed(inExp) < -BIAS_OFF))
      |=> (resultQ[WORD_W-2:0] == '0 && resultQ[WORD_W-1] == $past(inSign)));  // R4
  AST_ZERO_MANT_SIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (inMant == '0))
      |=> (resultQ == {$past(inSign), {(WORD_W-1){1'b0}}}));  // R5
  AST_EXP_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inMant[MANT_W-1] && ($signed(inExp) >= -BIAS_OFF)
      && ($signed(inExp) <= MAX_NORM_E))
      |=> ((resultQ[WORD_W-2:FRAC_W] == FIELD_W'($past(inExp) + EXP_W'(BIAS_OFF + 1)))
        || (resultQ[WORD_W-2:FRAC_W] == FIELD_W'($past(inExp) + EXP_W'(BIAS_OFF + 2)))));  // R1
  AST_SIGN_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && ($signed(inExp) <= MAX_NORM_E))
      |=> (resultQ[WORD_W-1] == $past(inSign)));  // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(resultQ));  // R8

endmodule

// File: rtl/fpack_round_unit.sv
module fpack_round_unit
  import fpack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSign,
  input  logic [15:0] inExp,
  input  logic [54:0] inMant,
  output logic        outValid,
  output logic [63:0] outWord
);

  packStrobe_t strobe;

  fpack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fpack_datapath #(
    .WORD_W   (DEF_WORD_W),
    .FRAC_W   (DEF_FRAC_W),
    .EXP_W    (DEF_EXP_W),
    .MANT_W   (DEF_MANT_W),
    .BIAS_OFF (DEF_BIAS_OFF)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inSign  (inSign),
    .inExp   (inExp),
    .inMant  (inMant),
    .outWord (outWord)
  );

endmodule

// File: tb/fpack_round_unit_tb.sv
module fpack_round_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inSign = 1'b0;
  logic [15:0] inExp = '0;
  logic [54:0] inMant = '0;
  logic        outValid;
  logic [63:0] outWord;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  fpack_round_unit u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSign   (inSign),
    .inExp    (inExp),
    .inMant   (inMant),
    .outValid (outValid),
    .outWord  (outWord)
  );

  // Model of the arithmetic: round m*2^e to nearest, ties to even.
  function automatic logic [63:0] refPack(input logic s, input int e, input logic [54:0] m);
    logic [52:0] kept;
    logic        up;
    int          bexp;
    if (e < -1076) return {s, 63'b0};
    kept = m[54:2];
    up   = m[1] && (m[0] || m[2]);
    if (!m[54]) return {s, 63'b0} + 64'(kept) + 64'(up);
    bexp = e + 1077;
    if (up) begin
      if (kept == {53{1'b1}}) begin
        kept = 53'h10000000000000;
        bexp = bexp + 1;
      end else begin
        kept = kept + 53'd1;
      end
    end
    return {s, 11'(bexp), kept[51:0]};
  endfunction

  function automatic string reqOf(input int e, input logic [54:0] m);
    if (e < -1076) return "R4";
    if (!m[54]) return "R5";
    if (e == -1076) return "R6";
    if (m[54:0] == {55{1'b1}}) return "R3";
    if (m[2:0] == 3'b011 || m[2:0] >= 3'b110) return "R2";
    return "R1";
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one operand, check it one cycle later, then check hold (R7, R8).
  task automatic applyOne(input logic s, input int e, input logic [54:0] m);
    logic [63:0] want;
    want = refPack(s, e, m);
    @(negedge clk);
    inValid = 1'b1; inSign = s; inExp = 16'(e); inMant = m;
    @(negedge clk);
    inValid = 1'b0; inSign = ~s; inExp = ~16'(e); inMant = ~m;
    checkBit("R7", outValid, 1'b1);
    check64(reqOf(e, m), outWord, want);
    @(negedge clk);
    checkBit("R7", outValid, 1'b0);
    check64("R8", outWord, want);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7: watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [54:0] highs [3];
    int          exps [10];
    highs[0] = 55'h40000000000000;
    highs[1] = 55'h5A5A5A5A5A5A58;
    highs[2] = 55'h7FFFFFFFFFFFF8;
    exps = '{-1200, -1077, -1076, -1075, -54, -1, 0, 1, 500, 969};

    // R9: reset state
    repeat (3) @(negedge clk);
    checkBit("R9", outValid, 1'b0);
    check64("R9", outWord, 64'd0);
    rstN = 1'b1;

    // R1 R2 R3 R4 R6: sweep sign, exponent, mantissa pattern and low bits
    for (int s = 0; s < 2; s++)
      for (int ei = 0; ei < 10; ei++)
        for (int hi = 0; hi < 3; hi++)
          for (int lo = 0; lo < 8; lo++)
            applyOne(s[0], exps[ei], highs[hi] | 55'(lo));

    // R5: zero mantissa and mantissa without leading one
    applyOne(1'b0, 0, 55'd0);
    applyOne(1'b1, 0, 55'd0);
    applyOne(1'b1, -1076, 55'd0);
    applyOne(1'b0, 3, 55'h1F);
    applyOne(1'b1, 7, 55'h3FFFFFFFFFFFFF);

    // R1: exact value 1.0 encodes as 0x3FF0...
    checks++;
    if (refPack(1'b0, -54, 55'h40000000000000) !== 64'h3FF0000000000000) begin
      errors++;
      $display("FAIL R1: actual=%h expected=%h",
               refPack(1'b0, -54, 55'h40000000000000), 64'h3FF0000000000000);
    end

    // R7: back-to-back operands
    @(negedge clk);
    inValid = 1'b1; inSign = 1'b0; inExp = 16'd0; inMant = 55'h40000000000003;
    @(negedge clk);
    checkBit("R7", outValid, 1'b1);
    check64("R7", outWord, refPack(1'b0, 0, 55'h40000000000003));
    inValid = 1'b1; inSign = 1'b1; inExp = 16'hFFF0; inMant = 55'h60000000000004;
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R7", outValid, 1'b1);
    check64("R7", outWord, refPack(1'b1, -16, 55'h60000000000004));
    @(negedge clk);
    checkBit("R7", outValid, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule